// File: doc/BRIEF.md
# Credit-Based Transmit Queue Shaper

This block shapes one transmit queue by tracking a signed credit balance. While the queue holds frames but is not on the wire, credit grows by the idle slope on every update tick. While the queue is transmitting, credit falls by the send slope on every tick. The balance is clamped to an upper limit and to a lower (negative) limit. A downstream scheduler may start a frame from this queue only while the transmit-eligible output is high, which in shaped mode means the credit is zero or more.

Software loads the slope and limit inputs with values that are already scaled. Each slope is the requested slope times 1024 times a rate factor, divided by a speed divider. The rate factor and divider are 4 and 100000 at 100 Mb/s, and 8 and 1000000 at 1 Gb/s. Each limit is the requested credit times 8192, truncated to 32 bits. The speed select input sets how many clock cycles separate two update ticks. When shaping is off, or when the block is built as queue 0, the queue runs unshaped: credit stays at zero and the queue is always eligible.

Top module: `cbs_queue_shaper`

## Requirements
- R1: While `shape_en_i` is low, the credit is zero from the next cycle on and `eligible_o` is high.
- R2: An instance built with `QUEUE_IDX` = 0 never shapes. Its credit stays zero and `eligible_o` stays high whatever the inputs are.
- R3: On a tick, when `sending_i` is low and `has_data_i` is high, credit becomes min(credit + idle slope, high limit).
- R4: On a tick, when `sending_i` is high, credit becomes max(credit - send slope, -low limit). `sending_i` takes precedence over `has_data_i`.
- R5: On a tick, when the queue is idle and empty (both flags low) and credit is positive, credit becomes zero.
- R6: On a tick, when the queue is idle and empty and credit is zero or negative, credit becomes min(credit + idle slope, 0).
- R7: Credit changes only on ticks. Ticks come every `FAST_PERIOD` cycles with `speed_sel_i` = 1 and every `SLOW_PERIOD` cycles with `speed_sel_i` = 0. The tick counter restarts after each tick and after reset.
- R8: In shaped mode, `eligible_o` is high exactly when the registered credit is zero or more.
- R9: During reset, and for two clock edges after `rst_n` is released, the credit is zero and `eligible_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| shape_en_i | input | 1 | 1 = shaped mode, 0 = plain mode |
| speed_sel_i | input | 1 | 1 = fast link (tick every FAST_PERIOD cycles), 0 = slow link (tick every SLOW_PERIOD cycles) |
| has_data_i | input | 1 | Queue holds at least one frame |
| sending_i | input | 1 | Queue is transmitting |
| idle_slope_i | input | SLOPE_W | Scaled idle slope, unsigned |
| send_slope_i | input | SLOPE_W | Scaled send slope magnitude, unsigned |
| hi_credit_i | input | LIM_W | Upper credit limit, unsigned |
| lo_credit_i | input | LIM_W | Magnitude of the lower credit limit, unsigned |
| credit_o | output | LIM_W+1 | Signed credit balance |
| eligible_o | output | 1 | Queue may start a frame |

## Verification
A wrong clamp or a wrong sign extension changes `credit_o` on the tick where it takes effect, so the error is visible one cycle after the inputs that cause it. A drifting tick counter moves the first credit change by at least one cycle, and the next per-cycle comparison catches it. A stale or inverted sign term shows up in `eligible_o` in the same cycle that `credit_o` crosses zero. Large limit and slope values drive the sum through its widest range, which exposes any truncation before the clamp on the first such tick.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_DRAIN = 2'd2,
    ACT_EMPTY = 2'd3
  } cbs_act_e;
endpackage

// File: rtl/cbs_tick_gen.sv
module cbs_tick_gen #(
  parameter int FAST_PERIOD = 1,
  parameter int SLOW_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic speed_sel_i,
  output logic tick_o
);
  localparam int MAXP  = (FAST_PERIOD > SLOW_PERIOD) ? FAST_PERIOD : SLOW_PERIOD;
  localparam int CNT_W = (MAXP > 1) ? $clog2(MAXP) + 1 : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = speed_sel_i ? CNT_W'(FAST_PERIOD - 1) : CNT_W'(SLOW_PERIOD - 1);
    tick_o = (cnt_q >= lim);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/cbs_action_sel.sv
module cbs_action_sel
  import cbs_pkg::*;
(
  input  logic     has_data_i,
  input  logic     sending_i,
  output cbs_act_e act_o
);
  always_comb begin
    if (sending_i)       act_o = ACT_DRAIN;
    else if (has_data_i) act_o = ACT_FILL;
    else                 act_o = ACT_EMPTY;
  end
endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
  import cbs_pkg::*;
#(
  parameter int LIM_W   = 32,
  parameter int SLOPE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    active_i,
  input  cbs_act_e                act_i,
  input  logic [SLOPE_W-1:0]      idle_slope_i,
  input  logic [SLOPE_W-1:0]      send_slope_i,
  input  logic [LIM_W-1:0]        hi_lim_i,
  input  logic [LIM_W-1:0]        lo_lim_i,
  output logic signed [LIM_W:0]   credit_o
);
  localparam int CW = LIM_W + 1;
  localparam int SW = ((LIM_W > SLOPE_W) ? LIM_W : SLOPE_W) + 3;

  logic signed [CW-1:0] credit_q, credit_d;
  logic signed [SW-1:0] cur, add_s, sub_s, hi_s, lo_s, sum, dif, nxt;
  logic                 en;

  always_comb begin
    cur   = SW'(credit_q);
    add_s = signed'(SW'(idle_slope_i));
    sub_s = signed'(SW'(send_slope_i));
    hi_s  = signed'(SW'(hi_lim_i));
    lo_s  = -signed'(SW'(lo_lim_i));
    sum   = cur + add_s;
    dif   = cur - sub_s;
    unique case (act_i)
      ACT_FILL:  nxt = (sum > hi_s) ? hi_s : sum;
      ACT_DRAIN: nxt = (dif < lo_s) ? lo_s : dif;
      ACT_EMPTY: begin
        if (cur > 0)      nxt = '0;
        else if (sum > 0) nxt = '0;
        else              nxt = sum;
      end
      default:   nxt = cur;
    endcase
    en       = tick_i || !active_i;
    credit_d = active_i ? CW'(nxt) : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  credit_q <= '0;
    else if (en)  credit_q <= credit_d;
  end

  assign credit_o = credit_q;

  // R3
  credit_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && active_i && act_i == ACT_FILL) |=>
      (SW'(credit_q) <= signed'(SW'($past(hi_lim_i)))));

  // R4
  credit_floor_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && active_i && act_i == ACT_DRAIN) |=>
      (SW'(credit_q) >= -signed'(SW'($past(lo_lim_i)))));

  // R5
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && active_i && act_i == ACT_EMPTY && credit_q > 0) |=> (credit_q == 0));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_i && active_i) |=> $stable(credit_q));

  // R1
  plain_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !active_i |=> (credit_q == 0));
endmodule

// File: rtl/cbs_queue_shaper.sv
module cbs_queue_shaper
  import cbs_pkg::*;
#(
  parameter int QUEUE_IDX   = 1,
  parameter int LIM_W       = 32,
  parameter int SLOPE_W     = 32,
  parameter int FAST_PERIOD = 1,
  parameter int SLOW_PERIOD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shape_en_i,
  input  logic                  speed_sel_i,
  input  logic                  has_data_i,
  input  logic                  sending_i,
  input  logic [SLOPE_W-1:0]    idle_slope_i,
  input  logic [SLOPE_W-1:0]    send_slope_i,
  input  logic [LIM_W-1:0]      hi_credit_i,
  input  logic [LIM_W-1:0]      lo_credit_i,
  output logic signed [LIM_W:0] credit_o,
  output logic                  eligible_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       active;
  cbs_act_e   act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  generate
    if (QUEUE_IDX == 0) begin : g_no_shape
      assign active = 1'b0;
    end else begin : g_shape
      assign active = shape_en_i;
    end
  endgenerate

  cbs_tick_gen #(
    .FAST_PERIOD (FAST_PERIOD),
    .SLOW_PERIOD (SLOW_PERIOD)
  ) u_tick (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .speed_sel_i (speed_sel_i),
    .tick_o      (tick)
  );

  cbs_action_sel u_act (
    .has_data_i (has_data_i),
    .sending_i  (sending_i),
    .act_o      (act)
  );

  cbs_credit_acc #(
    .LIM_W   (LIM_W),
    .SLOPE_W (SLOPE_W)
  ) u_acc (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .tick_i       (tick),
    .active_i     (active),
    .act_i        (act),
    .idle_slope_i (idle_slope_i),
    .send_slope_i (send_slope_i),
    .hi_lim_i     (hi_credit_i),
    .lo_lim_i     (lo_credit_i),
    .credit_o     (credit_o)
  );

  assign eligible_o = !active || !credit_o[LIM_W];

  // R8
  neg_blocks_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (active && credit_o < 0) |-> !eligible_o);

  // R2
  q0_plain_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (QUEUE_IDX == 0) |-> (eligible_o && credit_o == 0));
endmodule

// File: tb/cbs_queue_shaper_test.sv
module cbs_queue_shaper_test;
  localparam int LW = 32;
  localparam int SWD = 32;
  localparam int FP = 1;
  localparam int SP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shape_en = 1'b0, speed_sel = 1'b1, has_data = 1'b0, sending = 1'b0;
  logic [SWD-1:0] idle_sl = '0, send_sl = '0;
  logic [LW-1:0]  hi_c = '0, lo_c = '0;
  logic signed [LW:0] credit, credit0;
  logic eligible, eligible0;

  int errors = 0;
  int checks = 0;
  longint m_credit = 0;
  int m_cnt = 0;
  int m_hold = 0;
  string m_tag = "R9";

  always #5 clk = ~clk;

  cbs_queue_shaper #(.QUEUE_IDX(1), .LIM_W(LW), .SLOPE_W(SWD),
                     .FAST_PERIOD(FP), .SLOW_PERIOD(SP)) uut (
    .clk(clk), .rst_n(rst_n), .shape_en_i(shape_en), .speed_sel_i(speed_sel),
    .has_data_i(has_data), .sending_i(sending), .idle_slope_i(idle_sl),
    .send_slope_i(send_sl), .hi_credit_i(hi_c), .lo_credit_i(lo_c),
    .credit_o(credit), .eligible_o(eligible));

  cbs_queue_shaper #(.QUEUE_IDX(0), .LIM_W(LW), .SLOPE_W(SWD),
                     .FAST_PERIOD(FP), .SLOW_PERIOD(SP)) uut_q0 (
    .clk(clk), .rst_n(rst_n), .shape_en_i(shape_en), .speed_sel_i(speed_sel),
    .has_data_i(has_data), .sending_i(sending), .idle_slope_i(idle_sl),
    .send_slope_i(send_sl), .hi_credit_i(hi_c), .lo_credit_i(lo_c),
    .credit_o(credit0), .eligible_o(eligible0));

  function automatic longint next_credit(longint c, logic snd, logic dat,
                                         longint idl, longint sdl,
                                         longint hi, longint lo);
    longint r;
    if (snd) begin
      r = c - sdl;
      if (r < -lo) r = -lo;
    end else if (dat) begin
      r = c + idl;
      if (r > hi) r = hi;
    end else if (c > 0) begin
      r = 0;
    end else begin
      r = c + idl;
      if (r > 0) r = 0;
    end
    return r;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, longint'(credit), m_credit);
    chk(shape_en ? "R8" : "R1", longint'(eligible),
        (!shape_en || m_credit >= 0) ? 1 : 0);
    chk("R2", longint'(credit0), 0);
    chk("R2", longint'(eligible0), 1);
  endtask

  // One clock: model the coming edge from present inputs, then compare.
  task automatic cycle();
    longint nx;
    bit tick;
    int per;
    nx = m_credit;
    if (m_hold > 0) begin
      m_hold--;
      m_tag = "R9";
    end else begin
      per = speed_sel ? FP : SP;
      tick = (m_cnt >= per - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      if (!shape_en) begin
        nx = 0; m_tag = "R1";
      end else if (!tick) begin
        m_tag = "R7";
      end else begin
        nx = next_credit(m_credit, sending, has_data, longint'(idle_sl),
                         longint'(send_sl), longint'(hi_c), longint'(lo_c));
        m_tag = sending ? "R4" : has_data ? "R3" : (m_credit > 0) ? "R5" : "R6";
      end
    end
    @(negedge clk);
    m_credit = nx;
    compare_all();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: held in reset
    chk("R9", longint'(credit), 0);
    chk("R9", longint'(eligible), 1);
    rst_n = 1'b1;
    m_hold = 2;
    shape_en = 1'b1; speed_sel = 1'b1;
    hi_c = 100; lo_c = 50; idle_sl = 30; send_sl = 40;
    has_data = 1'b1;
    // R9 then R3: fill up to the high limit
    repeat (6) cycle();
    chk("R3", longint'(credit), 100);
    // R4: drain to the floor, sending wins over data
    sending = 1'b1;
    repeat (6) cycle();
    chk("R4", longint'(credit), -50);
    chk("R8", longint'(eligible), 0);
    // R6: empty queue recovers to zero but not above
    sending = 1'b0; has_data = 1'b0; idle_sl = 20;
    repeat (4) cycle();
    chk("R6", longint'(credit), 0);
    // R5: positive credit cleared when empty
    has_data = 1'b1; cycle(); cycle();
    has_data = 1'b0; cycle();
    chk("R5", longint'(credit), 0);
    // R7: slow speed, ticks every SP cycles
    speed_sel = 1'b0; has_data = 1'b1; idle_sl = 7; hi_c = 1000;
    repeat (12) cycle();
    // R1: shaping off clears credit
    shape_en = 1'b0; repeat (3) cycle();
    chk("R1", longint'(credit), 0);
    chk("R1", longint'(eligible), 1);
    // wide values: R3 and R4 at the edges of the range
    shape_en = 1'b1; speed_sel = 1'b1;
    hi_c = 32'hFFFF_FFFF; lo_c = 32'hFFFF_FFFF;
    idle_sl = 32'hFFFF_FFFF; send_sl = 32'hFFFF_FFFF;
    has_data = 1'b1; repeat (2) cycle();
    chk("R3", longint'(credit), 64'h0000_0000_FFFF_FFFF);
    sending = 1'b1; repeat (3) cycle();
    chk("R4", longint'(credit), -64'sh0000_0000_FFFF_FFFF);
    sending = 1'b0;
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) speed_sel = $urandom % 2;
      if (($urandom % 64) == 0) shape_en = ($urandom % 4) != 0;
      has_data = $urandom % 2;
      sending  = ($urandom % 3) == 0;
      if (($urandom % 32) == 0) begin
        hi_c    = $urandom % 200;
        lo_c    = $urandom % 200;
        idle_sl = $urandom % 60;
        send_sl = $urandom % 60;
      end
      cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule